// File: doc/BRIEF.md
# Divider-Tapped Interval Timer with Delayed Reload

This block is a small memory-mapped timer. A 16-bit divider advances on every clock, and its upper byte can be read. An 8-bit counter advances when one chosen divider bit goes from 1 to 0. The control register selects that bit and holds the enable. When the counter wraps from 0xFF to 0x00, it stays at zero for a fixed number of clocks. It then loads the value of an 8-bit modulo register, and a one-clock interrupt pulse follows.

The block reproduces the exact cycle behaviour around that wrap:

- A counter write early in the wait window cancels the reload and the interrupt.
- A counter write in the last cycle of the window is lost.
- A modulo write in that same last cycle goes straight through to the counter.
- A write that clears the divider can itself produce a counter step. So can a control change, since both work through the same falling-edge detector.

Counter steps that arrive while a reload is pending are dropped. Software reaches all four registers through one address/data port with a write strobe. Reads are combinational on the address.

Top module: `ptimer_top`

## Requirements
- R1: The divider increments by one on every clock. Address 0 reads the divider's upper byte. Any write to address 0, whatever the data, clears the whole divider to zero on that clock edge.
- R2: Control bit 2 is the enable. Control bits 1:0 select the divider bit: 00 selects bit 9, 01 bit 3, 10 bit 5 and 11 bit 7, giving periods of 1024, 16, 64 and 256 clocks. The counter increments on the clock after the enabled selected bit falls. With the enable clear, the counter holds.
- R3: Address 1 is the counter, address 2 the modulo value and address 3 the control register. Each reads back what was written. Control reads return only bits 2:0, with the upper bits zero.
- R4: When an increment takes the counter from 0xFF to 0x00, the counter reads 0x00 for 4 clocks. On the 4th clock edge after the wrap it loads the modulo value. The irq output is high for exactly the one cycle after that load.
- R5: A counter write in any of the first 3 cycles after a wrap takes effect. It cancels both the pending reload and the interrupt.
- R6: A counter write in the 4th cycle after a wrap (the reload cycle) is ignored. The modulo value is loaded and irq still pulses.
- R7: A modulo write in the reload cycle updates the modulo register and also loads the new value straight into the counter.
- R8: Clearing the divider while the enabled selected bit is 1 produces one counter increment on the following clock. This increment can wrap and start a reload like any other. Clearing the divider while that bit is 0 produces no increment.
- R9: A control write that takes the enabled selected bit from 1 to 0 produces one increment on the following clock. This applies whether the write clears the enable or moves to a tap whose bit is 0.
- R10: After reset, all four registers read zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the divider advances on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one write per clock |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | One-cycle interrupt pulse following a reload |

## Verification
The bound checker watches these rules on every cycle:

- The divider clears or steps by one.
- The counter stays at zero while a reload is pending.
- irq is a single-cycle pulse that follows only a reload cycle.
- The outcome of each write inside the reload window: cancel, ignore, or pass-through.

Only the bench's scenarios can show the rest:

- That each tap encoding gives its stated period.
- That the disabled counter holds.
- That divider clears and control changes produce exactly one spurious step when the tap bit was high and none when it was low.
- That a spurious step can itself wrap and raise irq.

// File: rtl/ptimer_pkg.sv
// Shared definitions for the divider-tapped timer.
// Assumes a 2-bit register address and a 3-bit control field.
package ptimer_pkg;

    // Register address map seen on the addr port
    typedef enum logic [1:0] {
        REG_DIV = 2'd0,
        REG_CNT = 2'd1,
        REG_MOD = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    localparam int CTL_W   = 3;   // stored control bits
    localparam int SEL_W   = 2;   // tap select field width
    localparam int EN_BIT  = 2;   // enable position in the control field
    localparam int N_TAPS  = 4;   // number of selectable divider bits

endpackage

// File: rtl/ptimer_divtap.sv
// Free-running divider plus tap selection and falling-edge detection.
// Assumes the enable and select inputs come from registers, so the tap
// level only changes at clock edges. A clear forces the divider to zero
// and is seen by the edge detector like any other change.
module ptimer_divtap
    import ptimer_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int TAP0  = 9,
    parameter int TAP1  = 3,
    parameter int TAP2  = 5,
    parameter int TAP3  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_clr,
    input  logic             tap_en,
    input  logic [SEL_W-1:0] tap_sel,
    output logic [DIV_W-1:0] div_q,
    output logic             tick
);

    localparam int TAP_LIST [N_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

    logic [N_TAPS-1:0] tap_vec;
    logic              tap_now;
    logic              tap_q;

    // Pick out each candidate divider bit
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign tap_vec[g] = div_q[TAP_LIST[g]];
    end

    // Gated level of the selected bit in the current state
    assign tap_now = tap_en & tap_vec[tap_sel];
    assign tick    = tap_q & ~tap_now;

    // Divider: clear on request, otherwise count every clock
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (div_clr) div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    // Remember the previous gated level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap_now;
    end

endmodule

// File: rtl/ptimer_ovf.sv
// Counter, modulo register and delayed-reload sequencer.
// Assumes at most one of cnt_we / mod_we per clock (single write port).
// pend_q counts down from RELOAD_DLY after a wrap; value 1 marks the
// reload cycle. Increments arriving while pend_q is non-zero are dropped.
module ptimer_ovf #(
    parameter int DATA_W     = 8,
    parameter int RELOAD_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_we,
    input  logic              mod_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] mod_q,
    output logic [$clog2(RELOAD_DLY+1)-1:0] pend_q,
    output logic              irq
);

    localparam int PW = $clog2(RELOAD_DLY + 1);
    localparam logic [PW-1:0] PEND_LAST = PW'(1);
    localparam logic [PW-1:0] PEND_INIT = PW'(RELOAD_DLY);

    logic reload_now;
    logic pending;
    logic wrap;

    assign reload_now = (pend_q == PEND_LAST);
    assign pending    = (pend_q != '0);
    assign wrap       = tick && (cnt_q == '1);

    // Modulo register: plain software write
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= '0;
        else if (mod_we) mod_q <= wdata;
    end

    // Interrupt pulse one cycle after the reload edge
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= reload_now;
    end

    // Counter value with reload, write and increment priority
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (reload_now) cnt_q <= mod_we ? wdata : mod_q;
        else if (cnt_we)     cnt_q <= wdata;
        else if (pending)    cnt_q <= cnt_q;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    // Reload countdown: start on wrap, cancel on counter write
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= '0;
        else if (reload_now) pend_q <= '0;
        else if (cnt_we)     pend_q <= '0;
        else if (pending)    pend_q <= pend_q - 1'b1;
        else if (wrap)       pend_q <= PEND_INIT;
    end

endmodule

// File: rtl/ptimer_regs.sv
// Address decode, control register storage and read multiplexer.
// Assumes reads are combinational and writes take effect at the edge.
module ptimer_regs
    import ptimer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [DATA_W-1:0] div_hi,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic [DATA_W-1:0] mod_q,
    output logic              div_clr,
    output logic              cnt_we,
    output logic              mod_we,
    output logic              tap_en,
    output logic [SEL_W-1:0]  tap_sel,
    output logic [DATA_W-1:0] rdata
);

    logic [CTL_W-1:0] ctl_q;
    logic             ctl_we;

    // Write strobes per register
    assign div_clr = wr_en && (addr == REG_DIV);
    assign cnt_we  = wr_en && (addr == REG_CNT);
    assign mod_we  = wr_en && (addr == REG_MOD);
    assign ctl_we  = wr_en && (addr == REG_CTL);

    assign tap_en  = ctl_q[EN_BIT];
    assign tap_sel = ctl_q[SEL_W-1:0];

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata;
    end

    // Read data selection
    always_comb begin
        case (addr)
            REG_DIV: rdata = div_hi;
            REG_CNT: rdata = cnt_q;
            REG_MOD: rdata = mod_q;
            default: rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
        endcase
    end

endmodule

// File: rtl/ptimer_top.sv
// Divider-tapped interval timer: top level wiring.
// Assumes a single register port with one access per clock.
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int DATA_W     = 8,
    parameter int RELOAD_DLY = 4,
    parameter int TAP0       = 9,
    parameter int TAP1       = 3,
    parameter int TAP2       = 5,
    parameter int TAP3       = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int PW = $clog2(RELOAD_DLY + 1);

    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] mod_q;
    logic [PW-1:0]     pend_q;
    logic              div_clr;
    logic              cnt_we;
    logic              mod_we;
    logic              tap_en;
    logic [SEL_W-1:0]  tap_sel;
    logic              tick;

    ptimer_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .ctl_wdata (wdata[CTL_W-1:0]),
        .div_hi    (div_q[DIV_W-1 -: DATA_W]),
        .cnt_q     (cnt_q),
        .mod_q     (mod_q),
        .div_clr   (div_clr),
        .cnt_we    (cnt_we),
        .mod_we    (mod_we),
        .tap_en    (tap_en),
        .tap_sel   (tap_sel),
        .rdata     (rdata)
    );

    ptimer_divtap #(
        .DIV_W(DIV_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_clr (div_clr),
        .tap_en  (tap_en),
        .tap_sel (tap_sel),
        .div_q   (div_q),
        .tick    (tick)
    );

    ptimer_ovf #(.DATA_W(DATA_W), .RELOAD_DLY(RELOAD_DLY)) u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt_we (cnt_we),
        .mod_we (mod_we),
        .wdata  (wdata),
        .cnt_q  (cnt_q),
        .mod_q  (mod_q),
        .pend_q (pend_q),
        .irq    (irq)
    );

endmodule

// File: rtl/ptimer_chk.sv
// Cycle-level property checker for ptimer_top, attached by bind.
// Assumes the top exposes div_q, cnt_q, mod_q and pend_q internally.
module ptimer_chk
    import ptimer_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int PW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_en,
    input logic              irq,
    input logic [DIV_W-1:0]  div_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] mod_q,
    input logic [PW-1:0]     pend_q
);

    localparam logic [PW-1:0] P_ONE  = PW'(1);
    localparam logic [PW-1:0] P_ZERO = '0;

    // R1
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIV) |=> (div_q == '0));

    // R1
    div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == REG_DIV) |=> (div_q == DIV_W'($past(div_q) + 1'b1)));

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pend_q == P_ONE));

    // R4
    reload_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == P_ONE) |=> irq);

    // R4
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != P_ZERO) |-> (cnt_q == '0));

    // R5
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q > P_ONE && wr_en && addr == REG_CNT)
        |=> (pend_q == P_ZERO && cnt_q == $past(wdata)));

    // R6
    reload_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == P_ONE && wr_en && addr == REG_CNT) |=> (cnt_q == $past(mod_q)));

    // R7
    reload_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == P_ONE && wr_en && addr == REG_MOD)
        |=> (cnt_q == $past(wdata) && mod_q == $past(wdata)));

endmodule

bind ptimer_top ptimer_chk #(
    .DIV_W(DIV_W), .DATA_W(DATA_W), .PW($clog2(RELOAD_DLY + 1))
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wdata  (wdata),
    .wr_en  (wr_en),
    .irq    (irq),
    .div_q  (div_q),
    .cnt_q  (cnt_q),
    .mod_q  (mod_q),
    .pend_q (pend_q)
);

// File: tb/ptimer_top_tb.sv
// Self-checking bench for ptimer_top: vector table then directed cases.
module ptimer_top_tb;

    localparam logic [1:0] A_DIV = 2'd0;
    localparam logic [1:0] A_CNT = 2'd1;
    localparam logic [1:0] A_MOD = 2'd2;
    localparam logic [1:0] A_CTL = 2'd3;

    // {ctl, mod, start, edge, expected count, expected irq}
    localparam int NV = 11;
    localparam logic [55:0] VECS [NV] = '{
        {8'h05, 8'h00, 8'h10, 16'd40,   8'h12, 8'h00},
        {8'h06, 8'h00, 8'h20, 16'd130,  8'h22, 8'h00},
        {8'h07, 8'h00, 8'h00, 16'd300,  8'h01, 8'h00},
        {8'h04, 8'h00, 8'h7F, 16'd1030, 8'h80, 8'h00},
        {8'h01, 8'h00, 8'h33, 16'd100,  8'h33, 8'h00},
        {8'h05, 8'hA0, 8'hFF, 16'd17,   8'h00, 8'h00},
        {8'h05, 8'hA0, 8'hFF, 16'd20,   8'h00, 8'h00},
        {8'h05, 8'hA0, 8'hFF, 16'd21,   8'hA0, 8'h01},
        {8'h05, 8'hA0, 8'hFF, 16'd22,   8'hA0, 8'h00},
        {8'h05, 8'hA0, 8'hFF, 16'd33,   8'hA1, 8'h00},
        {8'h05, 8'hFE, 8'hFF, 16'd37,   8'hFF, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int nchk = 0;
    int nerr = 0;
    int ecnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptimer_top u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        ecnt++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic goto(input int n);
        if (ecnt < n) begin
            while (ecnt < n) begin
                @(posedge clk);
                ecnt++;
            end
            @(negedge clk);
        end
    endtask

    // Reset, then program control, clear divider (edge 0), modulo, counter
    task automatic setup(input logic [7:0] c, input logic [7:0] m, input logic [7:0] s);
        do_reset();
        wr(A_CTL, c);
        wr(A_DIV, 8'h00);
        ecnt = 0;
        wr(A_MOD, m);
        wr(A_CNT, s);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;

        // R10 reset state
        do_reset();
        rd(A_DIV, v); chk("R10 div", v, 8'h00);
        rd(A_CNT, v); chk("R10 cnt", v, 8'h00);
        rd(A_MOD, v); chk("R10 mod", v, 8'h00);
        rd(A_CTL, v); chk("R10 ctl", v, 8'h00);
        chk("R10 irq", {7'b0, irq}, 8'h00);

        // R2 R4 vector table
        for (int i = 0; i < NV; i++) begin
            setup(VECS[i][55:48], VECS[i][47:40], VECS[i][39:32]);
            goto(int'(VECS[i][31:16]));
            rd(A_CNT, v);
            chk("R2/R4 table cnt", v, VECS[i][15:8]);
            chk("R2/R4 table irq", {7'b0, irq}, VECS[i][7:0]);
        end

        // R1 divider read and clear
        setup(8'h00, 8'h00, 8'h00);
        goto(300); rd(A_DIV, v); chk("R1 div at 300", v, 8'h01);
        goto(600); rd(A_DIV, v); chk("R1 div at 600", v, 8'h02);
        wr(A_DIV, 8'h5A); rd(A_DIV, v); chk("R1 div cleared", v, 8'h00);
        goto(855); rd(A_DIV, v); chk("R1 div at 254", v, 8'h00);
        goto(857); rd(A_DIV, v); chk("R1 div at 256", v, 8'h01);

        // R3 register readback
        wr(A_MOD, 8'h3C); rd(A_MOD, v); chk("R3 mod", v, 8'h3C);
        wr(A_CNT, 8'hC3); rd(A_CNT, v); chk("R3 cnt", v, 8'hC3);
        wr(A_CTL, 8'hFF); rd(A_CTL, v); chk("R3 ctl", v, 8'h07);

        // R5 cancel in first window cycle
        setup(8'h05, 8'hA0, 8'hFF);
        goto(17); wr(A_CNT, 8'h55);
        rd(A_CNT, v); chk("R5 write taken", v, 8'h55);
        for (int k = 19; k <= 24; k++) begin
            goto(k);
            chk("R5 no irq", {7'b0, irq}, 8'h00);
        end
        rd(A_CNT, v); chk("R5 no reload", v, 8'h55);

        // R5 cancel in last cancellable cycle
        setup(8'h05, 8'hA0, 8'hFF);
        goto(19); wr(A_CNT, 8'h66);
        goto(21); rd(A_CNT, v); chk("R5 late cancel cnt", v, 8'h66);
        goto(22); chk("R5 late cancel irq", {7'b0, irq}, 8'h00);

        // R6 counter write in reload cycle ignored
        setup(8'h05, 8'hA0, 8'hFF);
        goto(20); wr(A_CNT, 8'h55);
        rd(A_CNT, v); chk("R6 cnt", v, 8'hA0);
        chk("R6 irq", {7'b0, irq}, 8'h01);

        // R7 modulo write in reload cycle passes through
        setup(8'h05, 8'hA0, 8'hFF);
        goto(20); wr(A_MOD, 8'h77);
        rd(A_CNT, v); chk("R7 cnt", v, 8'h77);
        rd(A_MOD, v); chk("R7 mod", v, 8'h77);
        chk("R7 irq", {7'b0, irq}, 8'h01);

        // R8 divider clear with tap bit high
        setup(8'h05, 8'h00, 8'h10);
        goto(12); wr(A_DIV, 8'h00);
        rd(A_CNT, v); chk("R8 not yet", v, 8'h10);
        goto(14); rd(A_CNT, v); chk("R8 spurious step", v, 8'h11);

        // R8 spurious step wraps and reloads
        setup(8'h05, 8'hA0, 8'hFF);
        goto(12); wr(A_DIV, 8'h00);
        goto(14); rd(A_CNT, v); chk("R8 wrap", v, 8'h00);
        goto(18); rd(A_CNT, v); chk("R8 reload", v, 8'hA0);
        chk("R8 irq", {7'b0, irq}, 8'h01);

        // R8 divider clear with tap bit low
        setup(8'h05, 8'h00, 8'h10);
        goto(4); wr(A_DIV, 8'h00);
        goto(6); rd(A_CNT, v); chk("R8 no step", v, 8'h10);

        // R9 disabling while tap bit high
        setup(8'h05, 8'h00, 8'h10);
        goto(12); wr(A_CTL, 8'h01);
        goto(14); rd(A_CNT, v); chk("R9 disable step", v, 8'h11);

        // R9 tap change to a low bit
        setup(8'h05, 8'h00, 8'h10);
        goto(12); wr(A_CTL, 8'h06);
        goto(14); rd(A_CNT, v); chk("R9 tap change step", v, 8'h11);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule